// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Unlock

This block is a watchdog timer that software keeps alive by reloading it. A reload starts the first countdown stage from its preload. When that stage runs out, the block can raise an interrupt and then starts a second countdown from a second preload. If the second stage also runs out before the next reload, the block sets a sticky timeout flag and, when allowed, drives a reset request to the system reset logic.

The two preload registers and the reload/status register are protected. Each write to one of them has to be preceded by a two-value key sequence written to the reload register. A key opens the block for exactly one protected write, and the block then closes again by itself. A separate configuration word sets the tick rate, the interrupt behaviour and the reset-output behaviour. A separate control byte enables the timer and can lock it on.

The countdown runs on ticks from a prescaler. The slow rate divides the clock by 2^15 and the fast rate by 2^5. Equal preloads of N in both stages give a total timeout of 2·N ticks.

Top module: `wdt_two_stage`

## Requirements
- R1: After power-on reset, every bus register reads 0, the configuration word reads 0x0003, the control byte reads 0, and irq and wdt_rst are low.
- R2: The key is 0x0080 and then 0x0086, each written to offset 0xC with bytes 0 and 1 strobed. It arms exactly one write to offset 0x0, 0x4 or 0xC, and the block relocks after that write. A write to offset 0x8 does not use up the key.
- R3: Any write to offset 0xC that is not the expected next key value sends the key sequencer back to idle. A write to a protected register made without an armed key changes nothing.
- R4: The preloads at offset 0x0 (stage 1) and offset 0x4 (stage 2) are 20 bits wide and are updated per byte lane as bus_be selects.
- R5: A protected write to offset 0xC with bit 8 set restarts stage 1 from its preload and restarts the prescaler. If it lands in the same cycle as an expiry, the reload wins.
- R6: Stage 1 expires after its preload count of ticks. On expiry it sets bit 0 at offset 0x8, which drives irq, unless config bits [1:0] are 11. Writing 1 to bit 0 at offset 0x8 clears it, and this write needs no key.
- R7: Stage 2 expires after its own preload count of ticks. On expiry it sets bit 9 at offset 0xC. If config bit 5 is 0, it also raises wdt_rst, which stays high until a system reset.
- R8: Bit 9 at offset 0xC is cleared only by a protected write with bit 9 set, or by power-on reset. It survives a system reset.
- R9: With config bit 2 at 0, one tick lasts 2^15 clocks. With config bit 2 at 1, one tick lasts 2^5 clocks.
- R10: A preload of 0 counts as one tick.
- R11: The countdown runs only while control bit 1 is 1 and control bit 2 is 0 (watchdog mode). Otherwise the counters and the prescaler hold still.
- R12: While control bit 0 (lock) is 1, control bits 1 and 0 cannot be cleared and bit 2 cannot change. Only a system reset releases the lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including the timeout flag |
| sys_rst_n | input | 1 | System reset, active low; clears everything except the timeout flag |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_rdata | output | 32 | Read data for bus_addr |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration word write data |
| cfg_rdata | output | 16 | Configuration word readback |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte readback |
| irq | output | 1 | Stage 1 interrupt, level |
| wdt_rst | output | 1 | Reset request after stage 2 expiry |

## Verification
The critical overlap is a keyed reload that arrives on the same clock edge as the tick that would end stage 2. The bench provokes it by loading zero preloads, so each stage lasts one tick. It then places the two key writes early and times the reload write to land exactly 64 clocks after the previous reload. The bench judges the result by three observations: the timeout flag still reads 0, wdt_rst stays low, and a fresh full two-tick timeout follows from that edge.

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int CNT_W    = 20,
  parameter int DIV_SLOW = 15,
  parameter int DIV_FAST = 5
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        sys_rst_n,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [3:0]  bus_be,
  output logic [31:0] bus_rdata,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        ctl_we,
  input  logic [7:0]  ctl_wdata,
  output logic [7:0]  ctl_rdata,
  output logic        irq,
  output logic        wdt_rst
);

  localparam int PS_W = DIV_SLOW;
  localparam logic [PS_W-1:0] LIM_SLOW = PS_W'((64'd1 << DIV_SLOW) - 1);
  localparam logic [PS_W-1:0] LIM_FAST = PS_W'((64'd1 << DIV_FAST) - 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [1:0] SQ_IDLE = 2'd0, SQ_HALF = 2'd1, SQ_OPEN = 2'd2;
  localparam logic [1:0] ST_ONE = 2'd0, ST_TWO = 2'd1, ST_DONE = 2'd2;

  logic             all_rst_n;
  logic [1:0]       seq, seq_n;
  logic [CNT_W-1:0] pre1, pre2, cnt;
  logic [1:0]       stg;
  logic [PS_W-1:0]  ps;
  logic [15:0]      cfg;
  logic [7:0]       ctl;
  logic             ists, rst_q, flag;

  assign all_rst_n = sys_rst_n & por_n;

  function automatic logic [31:0] lane_mix(input logic [31:0] old, input logic [31:0] nw,
                                           input logic [3:0] be);
    for (int b = 0; b < 4; b++)
      lane_mix[8*b +: 8] = be[b] ? nw[8*b +: 8] : old[8*b +: 8];
  endfunction

  logic wr_pre1, wr_pre2, wr_ists, wr_rld, key1, key2, open, consume;
  assign wr_pre1 = bus_we && bus_addr == 4'h0;
  assign wr_pre2 = bus_we && bus_addr == 4'h4;
  assign wr_ists = bus_we && bus_addr == 4'h8;
  assign wr_rld  = bus_we && bus_addr == 4'hC;
  assign key1    = wr_rld && bus_be[1:0] == 2'b11 && bus_wdata[15:0] == 16'h0080;
  assign key2    = wr_rld && bus_be[1:0] == 2'b11 && bus_wdata[15:0] == 16'h0086;
  assign open    = seq == SQ_OPEN;
  assign consume = open && (wr_pre1 || wr_pre2 || wr_rld);

  logic do_reload, do_fclr;
  assign do_reload = open && wr_rld && bus_be[1] && bus_wdata[8];
  assign do_fclr   = open && wr_rld && bus_be[1] && bus_wdata[9];

  always_comb begin
    seq_n = seq;
    if (open) begin
      if (consume) seq_n = SQ_IDLE;
    end else if (wr_rld) begin
      if (seq == SQ_IDLE && key1)      seq_n = SQ_HALF;
      else if (seq == SQ_HALF && key2) seq_n = SQ_OPEN;
      else                             seq_n = SQ_IDLE;
    end
  end

  logic [31:0] mix1, mix2;
  assign mix1 = lane_mix(32'(pre1), bus_wdata, bus_be);
  assign mix2 = lane_mix(32'(pre2), bus_wdata, bus_be);

  logic run, tick, expire1, expire2;
  logic [CNT_W-1:0] pre1_eff, pre2_eff;
  assign run      = ctl[1] && !ctl[2];
  assign tick     = run && ps == (cfg[2] ? LIM_FAST : LIM_SLOW);
  assign expire1  = tick && !do_reload && stg == ST_ONE && cnt <= ONE;
  assign expire2  = tick && !do_reload && stg == ST_TWO && cnt <= ONE;
  assign pre1_eff = (pre1 == '0) ? ONE : pre1;
  assign pre2_eff = (pre2 == '0) ? ONE : pre2;

  always_ff @(posedge clk or negedge all_rst_n) begin
    if (!all_rst_n) begin
      seq   <= SQ_IDLE;
      pre1  <= '0;
      pre2  <= '0;
      cnt   <= ONE;
      stg   <= ST_ONE;
      ps    <= '0;
      cfg   <= 16'h0003;
      ctl   <= '0;
      ists  <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      seq <= seq_n;
      if (open && wr_pre1) pre1 <= mix1[CNT_W-1:0];
      if (open && wr_pre2) pre2 <= mix2[CNT_W-1:0];
      if (cfg_we) cfg <= cfg_wdata;
      if (ctl_we) begin
        if (ctl[0]) ctl <= {ctl_wdata[7:3], ctl[2], ctl[1] | ctl_wdata[1], 1'b1};
        else        ctl <= ctl_wdata;
      end
      if (do_reload || !run || tick) ps <= '0;
      else                           ps <= ps + 1'b1;
      if (do_reload) begin
        stg <= ST_ONE;
        cnt <= pre1_eff;
      end else if (tick && stg != ST_DONE) begin
        if (cnt > ONE)           cnt <= cnt - 1'b1;
        else if (stg == ST_ONE) begin
          stg <= ST_TWO;
          cnt <= pre2_eff;
        end else                 stg <= ST_DONE;
      end
      if (expire1 && cfg[1:0] != 2'b11)              ists <= 1'b1;
      else if (wr_ists && bus_be[0] && bus_wdata[0]) ists <= 1'b0;
      if (expire2 && !cfg[5]) rst_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        flag <= 1'b0;
    else if (expire2)  flag <= 1'b1;
    else if (do_fclr)  flag <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      4'h0:    bus_rdata = 32'(pre1);
      4'h4:    bus_rdata = 32'(pre2);
      4'h8:    bus_rdata = {31'b0, ists};
      4'hC:    bus_rdata = {22'b0, flag, 9'b0};
      default: bus_rdata = '0;
    endcase
  end

  assign cfg_rdata = cfg;
  assign ctl_rdata = ctl;
  assign irq       = ists;
  assign wdt_rst   = rst_q;

  a_r3_no_key_no_write: assert property (@(posedge clk) disable iff (!all_rst_n)
    (wr_pre1 && seq != SQ_OPEN) |=> $stable(pre1));

  a_r2_relock: assert property (@(posedge clk) disable iff (!all_rst_n)
    (seq == SQ_OPEN && (wr_pre1 || wr_pre2 || wr_rld)) |=> seq == SQ_IDLE);

  a_r12_lock_stays: assert property (@(posedge clk) disable iff (!all_rst_n)
    ctl[0] |=> (ctl[0] && $stable(ctl[2])));

  a_r12_enable_stays: assert property (@(posedge clk) disable iff (!all_rst_n)
    (ctl[0] && ctl[1]) |=> ctl[1]);

  a_r6_quiet_type: assert property (@(posedge clk) disable iff (!all_rst_n)
    (cfg[1:0] == 2'b11 && !ists) |=> !ists);

  a_r7_rst_with_flag: assert property (@(posedge clk) disable iff (!all_rst_n)
    $rose(wdt_rst) |-> flag);

  a_r11_frozen: assert property (@(posedge clk) disable iff (!all_rst_n)
    (!run && !do_reload) |=> ($stable(cnt) && $stable(stg)));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (flag && !do_fclr) |=> flag);

endmodule

// File: tb/tb_wdt_two_stage.sv
`timescale 1ns/1ps
module tb_wdt_two_stage;
  logic        clk = 1'b0;
  logic        por_n, sys_rst_n;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_be;
  logic [31:0] bus_rdata;
  logic        cfg_we;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        ctl_we;
  logic [7:0]  ctl_wdata;
  logic [7:0]  ctl_rdata;
  logic        irq, wdt_rst;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  wdt_two_stage dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .irq(irq), .wdt_rst(wdt_rst)
  );

  // {addr, be, wdata, check addr, expected, tag}
  localparam int NV = 25;
  localparam logic [99:0] VEC [NV] = '{
    {4'h0, 4'hF, 32'h0000_0005, 4'h0, 32'h0000_0000, "R3 "},
    {4'hC, 4'h3, 32'h0000_0080, 4'hC, 32'h0000_0000, "R2 "},
    {4'hC, 4'h3, 32'h0000_0086, 4'hC, 32'h0000_0000, "R2 "},
    {4'h0, 4'hF, 32'h0000_0005, 4'h0, 32'h0000_0005, "R2 "},
    {4'h0, 4'hF, 32'h0000_0007, 4'h0, 32'h0000_0005, "R2 "},
    {4'hC, 4'h3, 32'h0000_0080, 4'hC, 32'h0000_0000, "R3 "},
    {4'hC, 4'h3, 32'h0000_0055, 4'hC, 32'h0000_0000, "R3 "},
    {4'hC, 4'h3, 32'h0000_0086, 4'hC, 32'h0000_0000, "R3 "},
    {4'h0, 4'hF, 32'h0000_0009, 4'h0, 32'h0000_0005, "R3 "},
    {4'hC, 4'h3, 32'h0000_0080, 4'hC, 32'h0000_0000, "R2 "},
    {4'hC, 4'h3, 32'h0000_0086, 4'hC, 32'h0000_0000, "R2 "},
    {4'h4, 4'hF, 32'h0001_2345, 4'h4, 32'h0001_2345, "R4 "},
    {4'hC, 4'h3, 32'h0000_0080, 4'hC, 32'h0000_0000, "R2 "},
    {4'hC, 4'h3, 32'h0000_0086, 4'hC, 32'h0000_0000, "R2 "},
    {4'h4, 4'h1, 32'hFFFF_FFFF, 4'h4, 32'h0001_23FF, "R4 "},
    {4'hC, 4'h3, 32'h0000_0080, 4'hC, 32'h0000_0000, "R2 "},
    {4'hC, 4'h3, 32'h0000_0086, 4'hC, 32'h0000_0000, "R2 "},
    {4'h0, 4'hF, 32'hFFFF_FFFF, 4'h0, 32'h000F_FFFF, "R4 "},
    {4'hC, 4'h3, 32'h0000_0080, 4'hC, 32'h0000_0000, "R2 "},
    {4'hC, 4'h1, 32'h0000_0086, 4'hC, 32'h0000_0000, "R2 "},
    {4'h0, 4'hF, 32'h0000_0001, 4'h0, 32'h000F_FFFF, "R2 "},
    {4'hC, 4'h3, 32'h0000_0080, 4'hC, 32'h0000_0000, "R2 "},
    {4'hC, 4'h3, 32'h0000_0086, 4'hC, 32'h0000_0000, "R2 "},
    {4'h8, 4'hF, 32'h0000_0000, 4'h8, 32'h0000_0000, "R2 "},
    {4'h0, 4'hF, 32'h0000_0002, 4'h0, 32'h0000_0002, "R2 "}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic unlock();
    bus_wr(4'hC, 32'h80, 4'h3);
    bus_wr(4'hC, 32'h86, 4'h3);
  endtask

  task automatic pwr(input logic [3:0] a, input logic [31:0] d);
    unlock();
    bus_wr(a, d, 4'hF);
  endtask

  task automatic reload();
    unlock();
    bus_wr(4'hC, 32'h100, 4'h3);
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic cfg_wr(input logic [15:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ctl_wr(input logic [7:0] d);
    ctl_we = 1'b1; ctl_wdata = d;
    @(posedge clk); @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic sys_pulse();
    sys_rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    sys_rst_n = 1'b1;
  endtask

  task automatic clear_flag();
    unlock();
    bus_wr(4'hC, 32'h200, 4'h3);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    por_n = 1'b0; sys_rst_n = 1'b0;
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
    cfg_we = 1'b0; cfg_wdata = '0; ctl_we = 1'b0; ctl_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    por_n = 1'b1; sys_rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1", 4'h0, 0);
    rd_chk("R1", 4'h4, 0);
    rd_chk("R1", 4'h8, 0);
    rd_chk("R1", 4'hC, 0);
    check("R1", 32'(cfg_rdata), 32'h3);
    check("R1", 32'(ctl_rdata), 0);
    check("R1", 32'(irq), 0);
    check("R1", 32'(wdt_rst), 0);

    for (int i = 0; i < NV; i++) begin
      logic [99:0] v;
      v = VEC[i];
      bus_wr(v[99:96], v[91:60], v[95:92]);
      rd_chk(string'(v[23:0]), v[59:56], v[55:24]);
    end

    // R6 / R7: stage timing at fast rate, preloads 2 and 3
    cfg_wr(16'h0004);
    pwr(4'h0, 2);
    pwr(4'h4, 3);
    ctl_wr(8'h02);
    reload();
    wait_cyc(63); check("R6", 32'(irq), 0);
    wait_cyc(1);  check("R6", 32'(irq), 1);
    rd_chk("R6", 4'h8, 1);
    wait_cyc(95); check("R7", 32'(wdt_rst), 0);
    rd_chk("R7", 4'hC, 0);
    wait_cyc(1);  check("R7", 32'(wdt_rst), 1);
    rd_chk("R7", 4'hC, 32'h200);

    // R6 clear without key
    bus_wr(4'h8, 32'h1, 4'h1);
    check("R6", 32'(irq), 0);

    // R8 flag ignores unkeyed clear and survives system reset
    bus_wr(4'hC, 32'h200, 4'h3);
    rd_chk("R8", 4'hC, 32'h200);
    sys_pulse();
    rd_chk("R8", 4'hC, 32'h200);
    check("R7", 32'(wdt_rst), 0);
    check("R12", 32'(ctl_rdata), 0);
    clear_flag();
    rd_chk("R8", 4'hC, 0);

    // R10 zero preloads, R5 reload on the expiry edge
    cfg_wr(16'h0004);
    ctl_wr(8'h02);
    reload();
    unlock();
    wait_cyc(29); check("R10", 32'(irq), 0);
    wait_cyc(1);  check("R10", 32'(irq), 1);
    wait_cyc(31); check("R10", 32'(wdt_rst), 0);
    bus_wr(4'hC, 32'h100, 4'h3);
    rd_chk("R5", 4'hC, 0);
    check("R5", 32'(wdt_rst), 0);
    wait_cyc(63); check("R5", 32'(wdt_rst), 0);
    wait_cyc(1);  check("R10", 32'(wdt_rst), 1);
    sys_pulse();
    clear_flag();

    // R12 lock; R6 quiet type; R7 reset output disabled
    cfg_wr(16'h0027);
    ctl_wr(8'h03);
    ctl_wr(8'h00);
    check("R12", 32'(ctl_rdata), 32'h03);
    ctl_wr(8'h07);
    check("R12", 32'(ctl_rdata), 32'h03);
    reload();
    wait_cyc(70);
    check("R6", 32'(irq), 0);
    check("R7", 32'(wdt_rst), 0);
    rd_chk("R7", 4'hC, 32'h200);
    sys_pulse();
    check("R12", 32'(ctl_rdata), 0);
    clear_flag();

    // R11 mode bit stops the count
    cfg_wr(16'h0004);
    ctl_wr(8'h06);
    reload();
    wait_cyc(200);
    check("R11", 32'(irq), 0);
    check("R11", 32'(wdt_rst), 0);
    ctl_wr(8'h02);
    wait_cyc(31); check("R11", 32'(irq), 0);
    wait_cyc(1);  check("R11", 32'(irq), 1);

    // R9 slow rate
    sys_pulse();
    ctl_wr(8'h02);
    reload();
    wait_cyc(65535); check("R9", 32'(wdt_rst), 0);
    wait_cyc(1);     check("R9", 32'(wdt_rst), 1);
    rd_chk("R9", 4'hC, 32'h200);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule